// File: doc/BRIEF.md
# NAND Address Cycle Generator

This block converts a block number and a page number into the ordered address bytes that a NAND flash device expects after a command byte. The caller supplies the device geometry with each request: the pages per block, the number of blocks, and a flag that marks a large-page device. From these the block works out how many column bytes and row bytes the device needs. It also works out how far the block number must be shifted to sit above the page field of the row address.

A request is accepted on a `start` pulse while the block is idle. All inputs are captured at that moment. The address bytes then leave one per handshake on a valid/ready output, least significant first, and the final byte is flagged. A mode input selects one of two sequences. Full mode sends the column bytes followed by the row bytes, as used for page read and program. Row-only mode sends just the row bytes with the page field cleared, as used for block erase and lock-range commands.

Top module: `nand_addr_seq`

## Requirements
- R1: After reset `out_valid`, `out_last` and `busy` are low.
- R2: In full mode the sequence starts with column bytes of value 0x00: one byte when `large_page` is 0, two bytes when it is 1.
- R3: The row address equals `blk_num` shifted left by floor(log2(`pages_per_blk`)), ORed with `page_num`.
- R4: With n = (8 for small page, 16 for large page) + floor(log2(`pages_per_blk`)) + floor(log2(`blk_count`)), the full-mode sequence has 3 bytes for n ≤ 24, 4 bytes for 25 ≤ n ≤ 32, and 5 bytes above 32. The row bytes are that total minus the column bytes.
- R5: Bytes are emitted least significant first: all column bytes, then row bits [7:0], [15:8], and so on.
- R6: When `row_only` is 1, only the row bytes are emitted, and the page field is forced to zero whatever `page_num` holds.
- R7: `out_last` is high on the final byte of a sequence and low on every other byte. After the final byte is taken, `out_valid` drops.
- R8: While `out_valid` is high and `out_ready` is low, `out_byte` and `out_last` hold their values.
- R9: A `start` pulse while `busy` is high is ignored. Inputs that change after acceptance do not alter the sequence in progress.
- R10: For counts that are not a power of two, log2 rounds down. For example, 48 pages per block counts as 5 bits and 1000 blocks as 9 bits.
- R11: The first byte is valid in the cycle after `start` is accepted. Each following byte is valid in the cycle after the previous handshake, with no idle cycle between bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request pulse; accepted only while idle |
| blk_num | input | BLK_W | Block number |
| page_num | input | PG_W | Page number within the block |
| pages_per_blk | input | PPB_W | Pages per block (power of two expected) |
| blk_count | input | NBLK_W | Number of blocks in the device |
| large_page | input | 1 | 1 = page of 2048 bytes or more |
| row_only | input | 1 | 1 = row bytes only, page field zeroed |
| busy | output | 1 | A sequence is in progress |
| out_valid | output | 1 | `out_byte` holds an address byte |
| out_ready | input | 1 | Consumer takes the byte on this edge when valid |
| out_byte | output | 8 | Address byte |
| out_last | output | 1 | Final byte of the sequence |

## Verification
All results are registered exactly once. The first byte therefore appears one cycle after the edge that accepts `start`, and each later byte appears one cycle after the edge that completes the previous handshake. The bench drives inputs and samples outputs on the falling edge. It checks the first byte at the falling edge that follows the accepting rising edge, and each following byte one clock later, while `out_ready` is held high. In the stall scenario, the held byte is checked at two successive falling edges with `out_ready` low. After the final byte, the bench checks one falling edge later that `out_valid` is low.

// File: rtl/nas_pkg.sv
// Package: shared constants and types of the NAND address cycle generator.
// Assumes at most five address bytes, which covers every geometry the rules allow.
package nas_pkg;
    localparam int BYTE_W    = 8;
    localparam int MAX_BYTES = 5;
    localparam int ADDR_W    = BYTE_W * MAX_BYTES;
    localparam int CNT_W     = $clog2(MAX_BYTES + 1);
    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [ADDR_W-1:0] addr_t;
endpackage

// File: rtl/nas_flog2.sv
// Module: floor base-2 logarithm of an unsigned count.
// Assumes power-of-two inputs; other values round down, and zero yields zero.
module nas_flog2 #(
    parameter int IN_W  = 16,
    parameter int OUT_W = $clog2(IN_W) + 1
) (
    input  logic [IN_W-1:0]  value,
    output logic [OUT_W-1:0] lg
);
    // Index of the highest set bit.
    always_comb begin
        lg = '0;
        for (int i = 0; i < IN_W; i++) begin
            if (value[i]) lg = OUT_W'(i);
        end
    end
endmodule

// File: rtl/nas_geom.sv
// Module: derives column, row and total address byte counts from the geometry.
// Assumes log inputs already rounded down; page shift is 8 or 16 bits.
module nas_geom
    import nas_pkg::*;
#(
    parameter int LP_W = 4,
    parameter int LB_W = 5
) (
    input  logic [LP_W-1:0] lg_ppb,
    input  logic [LB_W-1:0] lg_blk,
    input  logic            large_page,
    output cnt_t            col_cnt,
    output cnt_t            row_cnt,
    output cnt_t            total_cnt
);
    localparam int N_W = 8;
    logic [N_W-1:0] n_bits;

    // Total address bit span and the byte count bands it falls in.
    always_comb begin
        n_bits = (large_page ? N_W'(16) : N_W'(8)) + N_W'(lg_ppb) + N_W'(lg_blk);
        col_cnt = large_page ? cnt_t'(2) : cnt_t'(1);
        if (n_bits <= N_W'(24))      total_cnt = cnt_t'(3);
        else if (n_bits <= N_W'(32)) total_cnt = cnt_t'(4);
        else                         total_cnt = cnt_t'(5);
        row_cnt = total_cnt - col_cnt;
    end
endmodule

// File: rtl/nas_pack.sv
// Module: packs block and page into the row address and places it above the column bytes.
// Assumes page_num fits below the block field; row-only mode clears the page field.
module nas_pack
    import nas_pkg::*;
#(
    parameter int BLK_W = 16,
    parameter int PG_W  = 8,
    parameter int LP_W  = 4
) (
    input  logic [BLK_W-1:0] blk_num,
    input  logic [PG_W-1:0]  page_num,
    input  logic [LP_W-1:0]  lg_ppb,
    input  logic             row_only,
    input  cnt_t             col_cnt,
    output addr_t            word
);
    addr_t row;

    // Row word, then shift past the zero column bytes in full mode.
    always_comb begin
        row = (addr_t'(blk_num) << lg_ppb) | (row_only ? '0 : addr_t'(page_num));
        word = row_only ? row : (row << (BYTE_W * int'(col_cnt)));
    end
endmodule

// File: rtl/nas_emit.sv
// Module: captures a packed address word and streams it out a byte per handshake.
// Assumes load is only asserted while idle; count is 1..MAX_BYTES.
module nas_emit
    import nas_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  addr_t             word_in,
    input  cnt_t              cnt_in,
    output logic              busy,
    input  logic              out_ready,
    output logic [BYTE_W-1:0] out_byte,
    output logic              out_last
);
    addr_t shreg;
    cnt_t  left;

    // Load on request, shift down one byte per accepted handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            left  <= '0;
            busy  <= 1'b0;
        end else if (load) begin
            shreg <= word_in;
            left  <= cnt_in;
            busy  <= 1'b1;
        end else if (busy && out_ready) begin
            shreg <= shreg >> BYTE_W;
            left  <= left - cnt_t'(1);
            if (left == cnt_t'(1)) busy <= 1'b0;
        end
    end

    // Output taps.
    always_comb begin
        out_byte = shreg[BYTE_W-1:0];
        out_last = busy && (left == cnt_t'(1));
    end
endmodule

// File: rtl/nand_addr_seq.sv
// Module: NAND address cycle generator top.
// Turns block/page plus geometry into LSB-first address bytes on a valid/ready port.
// Assumes geometry is a power of two; inputs are sampled only when start is accepted.
module nand_addr_seq
    import nas_pkg::*;
#(
    parameter int BLK_W  = 16,
    parameter int PG_W   = 8,
    parameter int PPB_W  = 9,
    parameter int NBLK_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BLK_W-1:0]  blk_num,
    input  logic [PG_W-1:0]   page_num,
    input  logic [PPB_W-1:0]  pages_per_blk,
    input  logic [NBLK_W-1:0] blk_count,
    input  logic              large_page,
    input  logic              row_only,
    output logic              busy,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_byte,
    output logic              out_last
);
    localparam int LP_W = $clog2(PPB_W) + 1;
    localparam int LB_W = $clog2(NBLK_W) + 1;

    logic [LP_W-1:0] lg_ppb;
    logic [LB_W-1:0] lg_blk;
    cnt_t            col_cnt, row_cnt, total_cnt, seq_cnt;
    addr_t           word;
    logic            accept;

    nas_flog2 #(.IN_W(PPB_W),  .OUT_W(LP_W)) u_lg_ppb (.value(pages_per_blk), .lg(lg_ppb));
    nas_flog2 #(.IN_W(NBLK_W), .OUT_W(LB_W)) u_lg_blk (.value(blk_count),     .lg(lg_blk));

    nas_geom #(.LP_W(LP_W), .LB_W(LB_W)) u_geom (
        .lg_ppb(lg_ppb), .lg_blk(lg_blk), .large_page(large_page),
        .col_cnt(col_cnt), .row_cnt(row_cnt), .total_cnt(total_cnt)
    );

    nas_pack #(.BLK_W(BLK_W), .PG_W(PG_W), .LP_W(LP_W)) u_pack (
        .blk_num(blk_num), .page_num(page_num), .lg_ppb(lg_ppb),
        .row_only(row_only), .col_cnt(col_cnt), .word(word)
    );

    // Request acceptance and byte count for the selected mode.
    always_comb begin
        accept  = start && !busy;
        seq_cnt = row_only ? row_cnt : total_cnt;
    end

    nas_emit u_emit (
        .clk(clk), .rst_n(rst_n), .load(accept), .word_in(word), .cnt_in(seq_cnt),
        .busy(busy), .out_ready(out_ready), .out_byte(out_byte), .out_last(out_last)
    );

    // Valid follows the in-progress state.
    assign out_valid = busy;
endmodule

// File: rtl/nas_chk.sv
// Module: protocol checker for nand_addr_seq, attached by bind.
// Tracks its own byte index from each accepted request.
module nas_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       large_page,
    input logic       row_only,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_byte,
    input logic       out_last
);
    logic [2:0] idx;
    logic       cap_large, cap_row;

    // Byte index and captured mode per sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0; cap_large <= 1'b0; cap_row <= 1'b0;
        end else if (start && !busy) begin
            idx <= '0; cap_large <= large_page; cap_row <= row_only;
        end else if (out_valid && out_ready) begin
            idx <= idx + 3'd1;
        end
    end

    AST_IDLE_OUT_OF_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_valid && !out_last)); // R1
    AST_COLUMN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !cap_row && (idx < (cap_large ? 3'd2 : 3'd1))) |-> (out_byte == 8'h00)); // R2
    AST_BYTE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (idx < 3'd5)); // R4
    AST_LAST_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> !out_valid); // R7
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_byte) && $stable(out_last))); // R8
    AST_FIRST_BYTE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> out_valid); // R11
endmodule

bind nand_addr_seq nas_chk u_chk (.*);

// File: tb/nand_addr_seq_bench.sv
// Bench: directed scenarios for nand_addr_seq, one task each.
module nand_addr_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] blk_num = '0;
    logic [7:0]  page_num = '0;
    logic [8:0]  pages_per_blk = '0;
    logic [16:0] blk_count = '0;
    logic        large_page = 1'b0;
    logic        row_only = 1'b0;
    logic        busy, out_valid, out_last;
    logic        out_ready = 1'b1;
    logic [7:0]  out_byte;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    nand_addr_seq u_nand_addr_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .blk_num(blk_num), .page_num(page_num),
        .pages_per_blk(pages_per_blk), .blk_count(blk_count), .large_page(large_page),
        .row_only(row_only), .busy(busy), .out_valid(out_valid), .out_ready(out_ready),
        .out_byte(out_byte), .out_last(out_last)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Present a request at a falling edge; scramble inputs once accepted.
    task automatic issue(input logic [15:0] b, input logic [7:0] p, input logic [8:0] ppb,
                         input logic [16:0] nb, input logic lg, input logic ro);
        @(negedge clk);
        blk_num = b; page_num = p; pages_per_blk = ppb; blk_count = nb;
        large_page = lg; row_only = ro; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        blk_num = 16'hFFFF; page_num = 8'hFF; pages_per_blk = 9'd256;
        blk_count = 17'h10000; large_page = ~lg; row_only = ~ro;   // R9 capture at start
    endtask

    // Walk the expected bytes, optionally stalling or poking start mid-sequence.
    task automatic drain(input logic [39:0] exp, input int cnt, input bit stall,
                         input bit poke, input string tag);
        for (int i = 0; i < cnt; i++) begin
            if (stall && i == 1) begin
                out_ready = 1'b0;
                @(negedge clk);
                @(negedge clk);
                chk(out_valid && out_byte == exp[8*i +: 8], "R8 hold", out_byte, exp[8*i +: 8]);
                out_ready = 1'b1;
            end
            chk(out_valid, {tag, " R11 valid"}, out_valid, 1);
            chk(out_byte == exp[8*i +: 8], {tag, " R5 byte"}, out_byte, exp[8*i +: 8]);
            chk(out_last == (i == cnt - 1), {tag, " R7 last"}, out_last, (i == cnt - 1));
            if (poke && i == 1) start = 1'b1;   // R9 ignored while busy
            @(negedge clk);
            start = 1'b0;
        end
        chk(!out_valid, {tag, " R7 end"}, out_valid, 0);
    endtask

    task automatic t_reset();
        chk(!out_valid && !busy && !out_last, "R1 reset", {out_valid, busy, out_last}, 0);
    endtask

    task automatic t_small_four();   // R2 R3 R4: n=25 -> 4 bytes
        issue(16'h0123, 8'h05, 9'd32, 17'd4096, 1'b0, 1'b0);
        drain(40'h0000246500, 4, 1'b0, 1'b0, "R4 small n25");
    endtask

    task automatic t_large_five();   // R2 R3 R4: n=33 -> 5 bytes, two column bytes
        issue(16'h07AB, 8'h3F, 9'd64, 17'd2048, 1'b1, 1'b0);
        drain(40'h01EAFF0000, 5, 1'b0, 1'b0, "R2 large n33");
    endtask

    task automatic t_small_three();  // R4: n=20 -> 3 bytes
        issue(16'h00AB, 8'h0C, 9'd16, 17'd256, 1'b0, 1'b0);
        drain(40'h00000ABC00, 3, 1'b0, 1'b0, "R4 small n20");
    endtask

    task automatic t_edges();        // R4: n exactly 24 and 32
        issue(16'h005A, 8'h11, 9'd32, 17'd2048, 1'b0, 1'b0);
        drain(40'h00000B5100, 3, 1'b0, 1'b0, "R4 n24");
        issue(16'h03C5, 8'h2A, 9'd64, 17'd1024, 1'b1, 1'b0);
        drain(40'h00F16A0000, 4, 1'b0, 1'b0, "R4 n32");
    endtask

    task automatic t_row_only();     // R6: page ignored, no column bytes
        issue(16'h07AB, 8'h3F, 9'd64, 17'd2048, 1'b1, 1'b1);
        drain(40'h000001EAC0, 3, 1'b0, 1'b0, "R6 large row");
        issue(16'h0123, 8'h05, 9'd32, 17'd4096, 1'b0, 1'b1);
        drain(40'h0000002460, 3, 1'b0, 1'b0, "R6 small row");
    endtask

    task automatic t_non_pow2();     // R10: 48 -> 5 bits, 1000 -> 9 bits, n=22
        issue(16'h0003, 8'h07, 9'd48, 17'd1000, 1'b0, 1'b0);
        drain(40'h0000006700, 3, 1'b0, 1'b0, "R10 full");
        issue(16'h0003, 8'h07, 9'd48, 17'd1000, 1'b0, 1'b1);
        drain(40'h0000000060, 2, 1'b0, 1'b0, "R10 row");
    endtask

    task automatic t_stall();        // R8
        issue(16'h07AB, 8'h3F, 9'd64, 17'd2048, 1'b1, 1'b0);
        drain(40'h01EAFF0000, 5, 1'b1, 1'b0, "R8 stall");
    endtask

    task automatic t_busy_start();   // R9
        issue(16'h0123, 8'h05, 9'd32, 17'd4096, 1'b0, 1'b0);
        drain(40'h0000246500, 4, 1'b0, 1'b1, "R9 busy start");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_small_four();
        t_large_five();
        t_small_three();
        t_edges();
        t_row_only();
        t_non_pow2();
        t_stall();
        t_busy_start();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule